// File: doc/BRIEF.md
# One-Bit Prescaler-Stepped Watchdog

This block protects a processor against runaway software. Software arms it once with a strobe. After that, software has to keep clearing it. When it is not cleared in time, the block drives a reset pulse to the CPU. The state is a single bit. That bit steps on an overflow tick taken from one of two external dividers. One divider is a timebase divider running from the main clock. The other is a watch prescaler running from the subclock. A select input picks which tick counts.

The first selected tick after a clear sets the bit. A second selected tick, arriving while the bit is still set, fires the reset. The timeout therefore lands between one and two tick periods after the last clear, so software must clear within one tick period. With the timebase tick this is 2^20 half-main-clock periods, about 210 ms at 10 MHz, and the worst case is about 419 ms. With the watch tick it is 2^14 subclock periods, 500 ms at 32.768 kHz, and the worst case is 1 s.

Clearing the selected divider also clears the bit. A low-power mode indicator clears the bit and holds it at zero for as long as the indicator is high. The reset pulse lasts four instruction cycles. An instruction cycle is a parameterised number of system clocks. When the pulse ends, the block returns to its unarmed state.

Top module: `rg_watchdog`

## Requirements
- R1: After a clear, the first selected tick sets the counter bit without any reset. A second selected tick while the bit is set starts the CPU reset pulse.
- R2: Before the arm strobe, ticks of either source never start a reset.
- R3: `src_sel`=0 selects the timebase tick and `tb_clr`. `src_sel`=1 selects the watch tick and `wp_clr`. A tick of the unselected source has no effect.
- R4: Once armed, the block stays armed until a system reset or the end of its own reset pulse. No input disarms it, and a repeated arm strobe changes nothing.
- R5: `sw_kick` clears the counter bit. When `sw_kick` and a selected tick occur in the same cycle, the clear wins and no reset starts.
- R6: A clear strobe of the selected divider clears the counter bit. A clear strobe of the unselected divider does not.
- R7: While `low_pwr` is high, the counter bit is held at zero and ticks never start a reset.
- R8: `cpu_rst` rises in the cycle right after the clock edge that sampled the firing tick. It then stays high for exactly 4*ICYC_CLKS clocks.
- R9: After the pulse ends, the block is unarmed: ticks cause no reset until the next arm strobe. An arm strobe during the pulse is ignored.
- R10: The synchronous active-high `rst` holds `cpu_rst` low, disarms the block and clears the counter bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| src_sel | input | 1 | Count source: 0 timebase, 1 watch prescaler |
| tb_tick | input | 1 | Timebase divider overflow tick, one clock wide |
| wp_tick | input | 1 | Watch prescaler overflow tick, one clock wide |
| tb_clr | input | 1 | Timebase divider clear strobe |
| wp_clr | input | 1 | Watch prescaler clear strobe |
| sw_arm | input | 1 | Software arm strobe |
| sw_kick | input | 1 | Software clear strobe |
| low_pwr | input | 1 | High while in a sleep, stop or watch mode |
| cpu_rst | output | 1 | CPU reset pulse |

## Verification
Some properties are checked on every cycle. The counter bit is zero after any kick, any selected divider clear, any low-power cycle and any unarmed cycle. Each rising reset follows a set counter bit. Each pulse is exactly the configured width. The armed flag drops only at the end of a pulse.

Other behaviour can only be seen through the bench scenarios, because it depends on an ordered history of ticks and clears. These scenarios cover the one-then-two tick count, the effect of each clear kind on the next timeout, an unselected source being ignored, arm strobes ignored during the pulse, and the disarmed state after the pulse.

// File: rtl/rg_pkg.sv
package rg_pkg;

    typedef enum logic {
        SRC_TIMEBASE = 1'b0,
        SRC_WATCH    = 1'b1
    } rg_src_e;

    // One divider as seen by the watchdog: its overflow tick and its clear strobe
    typedef struct packed {
        logic tick;
        logic clr;
    } rg_tap_t;

    localparam int RG_NSRC        = 2;
    localparam int RG_RST_ICYCLES = 4;

    function automatic int rg_pulse_len(input int icyc_clks);
        return icyc_clks * RG_RST_ICYCLES;
    endfunction

endpackage

// File: rtl/rg_tap_sel.sv
module rg_tap_sel
    import rg_pkg::*;
#(
    parameter int NSRC = RG_NSRC,
    localparam int SELW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  rg_tap_t [NSRC-1:0] taps,
    input  logic [SELW-1:0]    sel,
    output rg_tap_t            chosen
);

    rg_tap_t [NSRC-1:0] masked;

    for (genvar g = 0; g < NSRC; g++) begin : g_mask
        assign masked[g] = (sel == SELW'(g)) ? taps[g] : '0;
    end

    always_comb begin
        chosen = '0;
        for (int i = 0; i < NSRC; i++) begin
            chosen = chosen | masked[i];
        end
    end

endmodule

// File: rtl/rg_bit_ctr.sv
module rg_bit_ctr (
    input  logic clk,
    input  logic rst,
    input  logic armed,
    input  logic hold,
    input  logic clear,
    input  logic step,
    output logic cnt_q,
    output logic fire
);

    logic frozen;

    assign frozen = clear || !armed || hold;
    // A clear has priority over a tick in the same cycle
    assign fire   = !frozen && step && cnt_q;

    always_ff @(posedge clk) begin
        if (rst || frozen) begin
            cnt_q <= 1'b0;
        end else if (step) begin
            cnt_q <= ~cnt_q;
        end
    end

endmodule

// File: rtl/rg_rst_pulse.sv
module rg_rst_pulse #(
    parameter int LEN = 4,
    localparam int CW = $clog2(LEN + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    output logic pulse,
    output logic ending
);

    logic [CW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
        end else if (fire) begin
            left_q <= CW'(LEN);
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign pulse  = (left_q != '0);
    assign ending = (left_q == CW'(1));

endmodule

// File: rtl/rg_watchdog.sv
module rg_watchdog
    import rg_pkg::*;
#(
    parameter int ICYC_CLKS = 1,
    localparam int PULSE_LEN = rg_pulse_len(ICYC_CLKS)
) (
    input  logic clk,
    input  logic rst,
    input  logic src_sel,
    input  logic tb_tick,
    input  logic wp_tick,
    input  logic tb_clr,
    input  logic wp_clr,
    input  logic sw_arm,
    input  logic sw_kick,
    input  logic low_pwr,
    output logic cpu_rst
);

    rg_tap_t [RG_NSRC-1:0] taps;
    rg_tap_t               chosen;
    logic                  armed;
    logic                  cnt_q;
    logic                  fire;
    logic                  pulse;
    logic                  ending;
    logic                  clr_any;

    assign taps[int'(SRC_TIMEBASE)] = '{tick: tb_tick, clr: tb_clr};
    assign taps[int'(SRC_WATCH)]    = '{tick: wp_tick, clr: wp_clr};

    rg_tap_sel #(.NSRC(RG_NSRC)) u_sel (
        .taps   (taps),
        .sel    (src_sel),
        .chosen (chosen)
    );

    assign clr_any = sw_kick || chosen.clr || low_pwr;

    rg_bit_ctr u_ctr (
        .clk   (clk),
        .rst   (rst),
        .armed (armed),
        .hold  (pulse),
        .clear (clr_any),
        .step  (chosen.tick),
        .cnt_q (cnt_q),
        .fire  (fire)
    );

    rg_rst_pulse #(.LEN(PULSE_LEN)) u_pulse (
        .clk    (clk),
        .rst    (rst),
        .fire   (fire),
        .pulse  (pulse),
        .ending (ending)
    );

    // Sticky arm flag: only a system reset or the end of a pulse drops it
    always_ff @(posedge clk) begin
        if (rst || ending) begin
            armed <= 1'b0;
        end else if (sw_arm && !pulse) begin
            armed <= 1'b1;
        end
    end

    assign cpu_rst = pulse;

endmodule

// File: rtl/rg_watchdog_chk.sv
module rg_watchdog_chk #(
    parameter int PULSE_LEN = 4
) (
    input logic clk,
    input logic rst,
    input logic src_sel,
    input logic tb_clr,
    input logic wp_clr,
    input logic sw_kick,
    input logic low_pwr,
    input logic cpu_rst,
    input logic armed,
    input logic cnt_q
);

    logic [15:0] hi_n;

    always_ff @(posedge clk) begin
        if (rst || !cpu_rst) begin
            hi_n <= '0;
        end else begin
            hi_n <= hi_n + 16'd1;
        end
    end

    // R1: a reset starts only from a set counter bit
    p_fire_from_set_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(cpu_rst) |-> $past(cnt_q));

    // R2: an unarmed block never holds a set bit
    p_idle_unarmed_r2: assert property (@(posedge clk) disable iff (rst)
        !armed |=> !cnt_q);

    // R4: armed stays set unless a pulse is running
    p_sticky_arm_r4: assert property (@(posedge clk) disable iff (rst)
        (armed && !cpu_rst) |=> armed);

    // R5: a software kick zeroes the bit and blocks a new pulse
    p_kick_clears_r5: assert property (@(posedge clk) disable iff (rst)
        sw_kick |=> (!cnt_q && !$rose(cpu_rst)));

    // R6: a clear of the selected divider zeroes the bit
    p_sel_clr_r6: assert property (@(posedge clk) disable iff (rst)
        ((!src_sel && tb_clr) || (src_sel && wp_clr)) |=> !cnt_q);

    // R7: low-power mode zeroes the bit and blocks a new pulse
    p_lowpwr_freeze_r7: assert property (@(posedge clk) disable iff (rst)
        low_pwr |=> (!cnt_q && !$rose(cpu_rst)));

    // R8: the pulse never exceeds its width
    p_pulse_max_r8: assert property (@(posedge clk) disable iff (rst)
        cpu_rst |-> (hi_n < 16'(PULSE_LEN)));

    // R8: the pulse never ends early
    p_pulse_full_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(cpu_rst) |-> (hi_n == 16'(PULSE_LEN)));

    // R9: the end of the pulse disarms the block
    p_disarm_after_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(cpu_rst) |-> !armed);

endmodule

bind rg_watchdog rg_watchdog_chk #(.PULSE_LEN(PULSE_LEN)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .src_sel (src_sel),
    .tb_clr  (tb_clr),
    .wp_clr  (wp_clr),
    .sw_kick (sw_kick),
    .low_pwr (low_pwr),
    .cpu_rst (cpu_rst),
    .armed   (armed),
    .cnt_q   (cnt_q)
);

// File: tb/rg_watchdog_test.sv
module rg_watchdog_test;

    localparam int ICYC  = 2;
    localparam int WIDTH = 4 * ICYC;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic src_sel = 1'b0;
    logic tb_tick = 1'b0, wp_tick = 1'b0, tb_clr = 1'b0, wp_clr = 1'b0;
    logic sw_arm = 1'b0, sw_kick = 1'b0, low_pwr = 1'b0;
    logic cpu_rst;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    rg_watchdog #(.ICYC_CLKS(ICYC)) uut (
        .clk(clk), .rst(rst), .src_sel(src_sel),
        .tb_tick(tb_tick), .wp_tick(wp_tick),
        .tb_clr(tb_clr), .wp_clr(wp_clr),
        .sw_arm(sw_arm), .sw_kick(sw_kick), .low_pwr(low_pwr),
        .cpu_rst(cpu_rst)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: cpu_rst actual %b expected %b", req, act, exp);
        end
    endtask

    // Drive one cycle of strobes, let one edge pass, sample at the next falling edge
    task automatic step(input logic t_tb, input logic t_wp, input logic c_tb,
                        input logic c_wp, input logic a, input logic k,
                        input logic lp);
        tb_tick = t_tb; wp_tick = t_wp; tb_clr = c_tb; wp_clr = c_wp;
        sw_arm = a; sw_kick = k; low_pwr = lp;
        @(negedge clk);
        tb_tick = 0; wp_tick = 0; tb_clr = 0; wp_clr = 0;
        sw_arm = 0; sw_kick = 0; low_pwr = 0;
    endtask

    task automatic idle();
        step(0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic tick_sel(input logic s);
        step(!s, s, 0, 0, 0, 0, 0);
    endtask

    task automatic tick_other(input logic s);
        step(s, !s, 0, 0, 0, 0, 0);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R10 reset state", cpu_rst, 1'b0);
    endtask

    // Measure the pulse already seen high; strobe arm during it
    task automatic measure_pulse(input logic s);
        int n = 0;
        while (cpu_rst === 1'b1 && n < 100) begin
            n++;
            step(0, 0, 0, 0, (n == 1), 0, 0);
        end
        checks++;
        if (n != WIDTH) begin
            errors++;
            $display("FAIL R8: pulse width actual %0d expected %0d", n, WIDTH);
        end
        for (int i = 0; i < 3; i++) begin
            tick_sel(s);
            chk("R9 disarmed after pulse", cpu_rst, 1'b0);
        end
    endtask

    // kind: 0 none, 1 kick, 2 own divider clear, 3 other divider clear,
    //       4 low power with ticks, 5 kick together with tick
    task automatic run_case(input logic s, input int kind);
        bit eff;
        src_sel = s;
        do_reset();
        for (int i = 0; i < 2; i++) begin
            tick_sel(s);
            chk("R2 unarmed tick", cpu_rst, 1'b0);
        end
        step(0, 0, 0, 0, 1, 0, 0);
        for (int i = 0; i < 2; i++) begin
            tick_other(s);
            chk("R3 unselected tick", cpu_rst, 1'b0);
        end
        tick_sel(s);
        chk("R1 first tick sets bit", cpu_rst, 1'b0);
        case (kind)
            1: begin step(0, 0, 0, 0, 0, 1, 0); chk("R5 kick", cpu_rst, 1'b0); end
            2: begin step(0, 0, !s, s, 0, 0, 0); chk("R6 own clear", cpu_rst, 1'b0); end
            3: begin step(0, 0, s, !s, 0, 0, 0); chk("R6 other clear", cpu_rst, 1'b0); end
            4: begin
                for (int i = 0; i < 3; i++) begin
                    step(!s, s, 0, 0, 0, 0, 1);
                    chk("R7 low power freeze", cpu_rst, 1'b0);
                end
            end
            5: begin step(!s, s, 0, 0, 0, 1, 0); chk("R5 kick beats tick", cpu_rst, 1'b0); end
            default: idle();
        endcase
        eff = (kind == 1 || kind == 2 || kind == 4 || kind == 5);
        tick_sel(s);
        chk(eff ? "R1 tick after clear sets only" : "R1 second tick fires",
            cpu_rst, !eff);
        if (eff) begin
            tick_sel(s);
            chk("R1 second tick fires", cpu_rst, 1'b1);
        end
        measure_pulse(s);
    endtask

    initial begin
        @(negedge clk);
        for (int s = 0; s < 2; s++) begin
            for (int k = 0; k < 6; k++) begin
                run_case(s[0], k);
            end
        end

        // R4: arm stays through a long quiet stretch and a repeated arm
        src_sel = 1'b1;
        do_reset();
        step(0, 0, 0, 0, 1, 0, 0);
        repeat (40) idle();
        step(0, 0, 0, 0, 1, 0, 0);
        tick_sel(1'b1);
        chk("R4 still armed first tick", cpu_rst, 1'b0);
        tick_sel(1'b1);
        chk("R4 still armed fires", cpu_rst, 1'b1);
        measure_pulse(1'b1);

        // R9: re-arm after a pulse works again
        step(0, 0, 0, 0, 1, 0, 0);
        tick_sel(1'b1);
        tick_sel(1'b1);
        chk("R9 re-arm fires", cpu_rst, 1'b1);

        // R10: reset mid-pulse and after arming disarms
        do_reset();
        step(0, 0, 0, 0, 1, 0, 0);
        tick_sel(1'b1);
        do_reset();
        for (int i = 0; i < 3; i++) begin
            tick_sel(1'b1);
            chk("R10 reset disarms", cpu_rst, 1'b0);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run hung, actual running expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule